// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides when a small processor core may stop its clock and when it must start again. The CPU raises a one-cycle power-down request. A configuration bit then picks one of two sleep flavours. In the locked flavour, only the external reset can end the sleep, and entry is allowed only while the non-maskable interrupt line is low. In the wakeable flavour, entry is allowed only when every enabled fast interrupt pin is at its inactive level. Any qualified interrupt pin, a real-time-clock interrupt, CAN activity or I2C activity ends that sleep.

Each fast interrupt pin must stay asserted for a minimum time before it counts as a wake. A per-pin counter measures this time, and it is sized from the clock period. After a wake, the block holds the clock gate for a settling period and then returns to normal running. A regulator-off permission bit is captured when the core goes to sleep. A regulator shutdown request is raised only if that bit was set. The external reset is the block's asynchronous reset and overrides everything. While reset is held, the RAM is disabled and its interface is frozen, so that a standby supply can be used safely.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: While extRstN is low: status reads 0, clkGate and regShutdown are 0, ramEn is 0 and ramFreeze is 1. After the first clock edge with extRstN high, ramEn is 1 and ramFreeze is 0.
- R2: With modeSel=0, a pdReq sampled while nmiLevel=0 moves the state field status[1:0] from RUN (0) to locked sleep (1) on that edge. When nmiLevel=1, the request leaves the state at RUN.
- R3: In locked sleep (state 1), fast interrupt pins, rtcIrq, canAct and i2cAct have no effect. The state stays at 1 and the cause bits stay 0.
- R4: With modeSel=1, a pdReq moves the state to wakeable sleep (2) only if no pin i has extIntEn[i]=1 and extIntPins[i]==extIntPol[i]. A polarity bit of 1 means active-high. Pins with the enable bit at 0 are ignored.
- R5: In state 2, rtcIrq, canAct or i2cAct sampled high moves the state to WAKING (3) on that edge. The same edge sets cause bits status[5], status[6] and status[7] respectively, and wakeEvent is high for exactly the following cycle.
- R6: An enabled pin wakes state 2 only after it has been sampled active on FILT_CYCLES consecutive edges, where FILT_CYCLES = ceil(MIN_PULSE_NS/CLK_PERIOD_NS) (4 by default). The wake takes effect on the next edge and sets status[4]. Shorter pulses and disabled pins leave the state at 2.
- R7: WAKING lasts exactly STAB_CYCLES cycles (8 by default), with clkGate high. The state then returns to RUN and clkGate drops.
- R8: regShutdown is high only in states 1 and 2, and only if regOffEn was 1 on the entry edge. Later changes of regOffEn have no effect until the next entry.
- R9: Cause bits status[7:4] are sticky. Each bit clears when the matching bit of causeClr (bit 0 maps to status[4]) is high on a clock edge, and a simultaneous set wins. Bits status[3:2] read 0.
- R10: Asserting extRstN low returns the controller to RUN from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| extRstN | input | 1 | External reset, active low, asynchronous |
| pdReq | input | 1 | One-cycle power-down request from the CPU |
| modeSel | input | 1 | 0 = locked sleep, 1 = wakeable sleep |
| regOffEn | input | 1 | Permission to shut down the main regulator during sleep |
| nmiLevel | input | 1 | Level of the non-maskable interrupt input |
| extIntPins | input | NUM_PINS | Fast external interrupt pin levels |
| extIntEn | input | NUM_PINS | Per-pin wake enable |
| extIntPol | input | NUM_PINS | Per-pin active level (1 = high) |
| rtcIrq | input | 1 | Real-time-clock interrupt |
| canAct | input | 1 | CAN interface activity |
| i2cAct | input | 1 | I2C interface activity |
| causeClr | input | 4 | Write-1-to-clear strobes for the cause bits |
| clkGate | output | 1 | Core clock stopped (sleep or settling) |
| regShutdown | output | 1 | Main regulator shutdown request |
| wakeEvent | output | 1 | One-cycle pulse after a wake |
| status | output | 8 | [1:0] state, [3:2] zero, [7:4] cause {i2c, can, rtc, pin} |
| ramEn | output | 1 | RAM enable, low while in reset |
| ramFreeze | output | 1 | Freezes the RAM interface while in reset |

## Verification
Entry qualification is swept over every combination of enable mask, polarity and pin level on four pins, with the other four pins held active but disabled. This separates an enabled active pin, which blocks entry, from a masked one, which does not, and checks that both polarities are honoured. Wake filtering is exercised on each of the eight pins with pulse widths from one to six cycles, so the width just below the threshold and the threshold itself are told apart on every pin. Locked sleep receives every wake source and must ignore all of them. The settling window, the sticky clear-on-write cause bits and the captured regulator permission are then checked against cycle counts worked out from the requirements.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_PD_LOCK  = 2'd1,
    ST_PD_WAKE  = 2'd2,
    ST_WAKING   = 2'd3
  } lpmState_e;

  // Control -> datapath strobes
  typedef struct packed {
    logic enterStb;  // entering either sleep state this edge
    logic wakeStb;   // leaving wakeable sleep this edge
  } lpmStrobe_t;

  localparam int CAUSE_W   = 4;
  localparam int CAUSE_PIN = 0;
  localparam int CAUSE_RTC = 1;
  localparam int CAUSE_CAN = 2;
  localparam int CAUSE_I2C = 3;

endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int NUM_PINS      = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int MIN_PULSE_NS  = 40,
  parameter int STAB_CYCLES   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lpmStrobe_t           stb,
  input  logic [NUM_PINS-1:0]  extIntPins,
  input  logic [NUM_PINS-1:0]  extIntEn,
  input  logic [NUM_PINS-1:0]  extIntPol,
  input  logic                 rtcIrq,
  input  logic                 canAct,
  input  logic                 i2cAct,
  input  logic                 regOffEn,
  input  logic [CAUSE_W-1:0]   causeClr,
  output logic                 pinsQuiet,
  output logic                 wakeReq,
  output logic                 stabDone,
  output logic                 regOffLatched,
  output logic [CAUSE_W-1:0]   cause,
  output logic                 wakeEvent,
  output logic                 ramEn
);

  localparam int FILT_CYCLES = (MIN_PULSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int FILT_LIM    = (FILT_CYCLES < 1) ? 1 : FILT_CYCLES;
  localparam int FILT_W      = $clog2(FILT_LIM + 1);
  localparam int STAB_W      = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [FILT_W-1:0] FILT_MAX  = FILT_W'(FILT_LIM);
  localparam logic [STAB_W-1:0] STAB_LOAD = STAB_W'(STAB_CYCLES - 1);

  logic [NUM_PINS-1:0] pinActive;
  logic [NUM_PINS-1:0] pinQual;
  logic [STAB_W-1:0]   stabCnt;
  logic [CAUSE_W-1:0]  causeSet;

  // Per-pin minimum-width filter
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_filt
    logic [FILT_W-1:0] widthCnt;

    assign pinActive[i] = extIntEn[i] & (extIntPins[i] == extIntPol[i]);
    assign pinQual[i]   = (widthCnt == FILT_MAX);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        widthCnt <= '0;
      end else if (!pinActive[i]) begin
        widthCnt <= '0;
      end else if (widthCnt != FILT_MAX) begin
        widthCnt <= widthCnt + 1'b1;
      end
    end
  end

  assign pinsQuiet = ~|pinActive;
  assign wakeReq   = (|pinQual) | rtcIrq | canAct | i2cAct;

  always_comb begin
    causeSet            = '0;
    causeSet[CAUSE_PIN] = |pinQual;
    causeSet[CAUSE_RTC] = rtcIrq;
    causeSet[CAUSE_CAN] = canAct;
    causeSet[CAUSE_I2C] = i2cAct;
  end

  // Sticky cause bits: clear first, set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cause <= '0;
    end else if (stb.wakeStb) begin
      cause <= (cause & ~causeClr) | causeSet;
    end else begin
      cause <= cause & ~causeClr;
    end
  end

  // Settling counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stabCnt <= '0;
    end else if (stb.wakeStb) begin
      stabCnt <= STAB_LOAD;
    end else if (stabCnt != '0) begin
      stabCnt <= stabCnt - 1'b1;
    end
  end

  assign stabDone = (stabCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regOffLatched <= 1'b0;
      wakeEvent     <= 1'b0;
      ramEn         <= 1'b0;
    end else begin
      if (stb.enterStb) begin
        regOffLatched <= regOffEn;
      end
      wakeEvent <= stb.wakeStb;
      ramEn     <= 1'b1;
    end
  end

endmodule

// File: rtl/lpm_control.sv
module lpm_control
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pdReq,
  input  logic       modeSel,
  input  logic       nmiLevel,
  input  logic       pinsQuiet,
  input  logic       wakeReq,
  input  logic       stabDone,
  input  logic       regOffLatched,
  output lpmStrobe_t stb,
  output lpmState_e  state,
  output logic       clkGate,
  output logic       regShutdown
);

  lpmState_e stateNxt;

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      ST_RUN: begin
        if (pdReq) begin
          if (!modeSel && !nmiLevel) begin
            stateNxt     = ST_PD_LOCK;
            stb.enterStb = 1'b1;
          end else if (modeSel && pinsQuiet) begin
            stateNxt     = ST_PD_WAKE;
            stb.enterStb = 1'b1;
          end
        end
      end
      ST_PD_LOCK: stateNxt = ST_PD_LOCK;
      ST_PD_WAKE: begin
        if (wakeReq) begin
          stateNxt    = ST_WAKING;
          stb.wakeStb = 1'b1;
        end
      end
      ST_WAKING: begin
        if (stabDone) begin
          stateNxt = ST_RUN;
        end
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
    end else begin
      state <= stateNxt;
    end
  end

  assign clkGate     = (state != ST_RUN);
  assign regShutdown = regOffLatched &&
                       ((state == ST_PD_LOCK) || (state == ST_PD_WAKE));

endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_PINS      = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int MIN_PULSE_NS  = 40,
  parameter int STAB_CYCLES   = 8
) (
  input  logic                clk,
  input  logic                extRstN,
  input  logic                pdReq,
  input  logic                modeSel,
  input  logic                regOffEn,
  input  logic                nmiLevel,
  input  logic [NUM_PINS-1:0] extIntPins,
  input  logic [NUM_PINS-1:0] extIntEn,
  input  logic [NUM_PINS-1:0] extIntPol,
  input  logic                rtcIrq,
  input  logic                canAct,
  input  logic                i2cAct,
  input  logic [3:0]          causeClr,
  output logic                clkGate,
  output logic                regShutdown,
  output logic                wakeEvent,
  output logic [7:0]          status,
  output logic                ramEn,
  output logic                ramFreeze
);

  lpmStrobe_t         stb;
  lpmState_e          state;
  logic               pinsQuiet;
  logic               wakeReq;
  logic               stabDone;
  logic               regOffLatched;
  logic [CAUSE_W-1:0] cause;

  lpm_control u_ctrl (
    .clk           (clk),
    .rstN          (extRstN),
    .pdReq         (pdReq),
    .modeSel       (modeSel),
    .nmiLevel      (nmiLevel),
    .pinsQuiet     (pinsQuiet),
    .wakeReq       (wakeReq),
    .stabDone      (stabDone),
    .regOffLatched (regOffLatched),
    .stb           (stb),
    .state         (state),
    .clkGate       (clkGate),
    .regShutdown   (regShutdown)
  );

  lpm_datapath #(
    .NUM_PINS      (NUM_PINS),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .MIN_PULSE_NS  (MIN_PULSE_NS),
    .STAB_CYCLES   (STAB_CYCLES)
  ) u_dp (
    .clk           (clk),
    .rstN          (extRstN),
    .stb           (stb),
    .extIntPins    (extIntPins),
    .extIntEn      (extIntEn),
    .extIntPol     (extIntPol),
    .rtcIrq        (rtcIrq),
    .canAct        (canAct),
    .i2cAct        (i2cAct),
    .regOffEn      (regOffEn),
    .causeClr      (causeClr),
    .pinsQuiet     (pinsQuiet),
    .wakeReq       (wakeReq),
    .stabDone      (stabDone),
    .regOffLatched (regOffLatched),
    .cause         (cause),
    .wakeEvent     (wakeEvent),
    .ramEn         (ramEn)
  );

  assign status    = {cause, 2'b00, state};
  assign ramFreeze = ~ramEn;

endmodule

// File: rtl/lpm_entry_ctrl_chk.sv
module lpm_entry_ctrl_chk (
  input logic       clk,
  input logic       extRstN,
  input logic       pdReq,
  input logic       modeSel,
  input logic       nmiLevel,
  input logic [3:0] causeClr,
  input logic       clkGate,
  input logic       regShutdown,
  input logic       wakeEvent,
  input logic [7:0] status
);

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!extRstN)
    (status[1:0] == 2'd1) |=> (status[1:0] == 2'd1));

  // R2
  lock_entry_chk: assert property (@(posedge clk) disable iff (!extRstN)
    (status[1:0] == 2'd0 && pdReq && !modeSel && !nmiLevel) |=> (status[1:0] == 2'd1));

  // R8
  reg_off_chk: assert property (@(posedge clk) disable iff (!extRstN)
    regShutdown |-> (clkGate && (status[1:0] == 2'd1 || status[1:0] == 2'd2)));

  // R7
  waking_gate_chk: assert property (@(posedge clk) disable iff (!extRstN)
    (status[1:0] == 2'd3) |-> clkGate);

  // R5
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!extRstN)
    $rose(wakeEvent) |-> (status[1:0] == 2'd3 && $past(status[1:0]) == 2'd2));

  // R9
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!extRstN)
    (causeClr == 4'd0 && status[1:0] != 2'd2) |=> $stable(status[7:4]));

endmodule

bind lpm_entry_ctrl lpm_entry_ctrl_chk u_chk (
  .clk         (clk),
  .extRstN     (extRstN),
  .pdReq       (pdReq),
  .modeSel     (modeSel),
  .nmiLevel    (nmiLevel),
  .causeClr    (causeClr),
  .clkGate     (clkGate),
  .regShutdown (regShutdown),
  .wakeEvent   (wakeEvent),
  .status      (status)
);

// File: tb/lpm_entry_ctrl_test.sv
module lpm_entry_ctrl_test;

  localparam int FILT = 4;
  localparam int STAB = 8;

  logic       clk = 1'b0;
  logic       extRstN, pdReq, modeSel, regOffEn, nmiLevel;
  logic [7:0] extIntPins, extIntEn, extIntPol;
  logic       rtcIrq, canAct, i2cAct;
  logic [3:0] causeClr;
  logic       clkGate, regShutdown, wakeEvent, ramEn, ramFreeze;
  logic [7:0] status;

  int errors = 0;
  int checks = 0;
  int wakingCycles;

  lpm_entry_ctrl uut (
    .clk(clk), .extRstN(extRstN), .pdReq(pdReq), .modeSel(modeSel),
    .regOffEn(regOffEn), .nmiLevel(nmiLevel), .extIntPins(extIntPins),
    .extIntEn(extIntEn), .extIntPol(extIntPol), .rtcIrq(rtcIrq),
    .canAct(canAct), .i2cAct(i2cAct), .causeClr(causeClr),
    .clkGate(clkGate), .regShutdown(regShutdown), .wakeEvent(wakeEvent),
    .status(status), .ramEn(ramEn), .ramFreeze(ramFreeze)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setIdle();
    pdReq = 0; rtcIrq = 0; canAct = 0; i2cAct = 0; causeClr = 0;
    extIntPins = ~extIntPol;
  endtask

  task automatic doReset();
    extRstN = 0;
    setIdle();
    @(negedge clk);
    @(negedge clk);
    extRstN = 1;
    @(negedge clk);
  endtask

  task automatic requestPd(input logic mode, input logic nmi, input logic regOff);
    pdReq = 1; modeSel = mode; nmiLevel = nmi; regOffEn = regOff;
    @(negedge clk);
    pdReq = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    extIntPol = 8'h00; extIntEn = 8'h00;
    modeSel = 0; nmiLevel = 0; regOffEn = 0;
    setIdle();
    extRstN = 0;
    @(negedge clk);
    // R1: state during reset
    chk("R1 status in reset", status, 0);
    chk("R1 ramEn in reset", ramEn, 0);
    chk("R1 ramFreeze in reset", ramFreeze, 1);
    chk("R1 clkGate in reset", clkGate, 0);
    chk("R1 regShutdown in reset", regShutdown, 0);
    extRstN = 1;
    @(negedge clk);
    chk("R1 ramEn after reset", ramEn, 1);
    chk("R1 ramFreeze after reset", ramFreeze, 0);

    // R2: locked entry qualified by NMI, R8 regulator capture
    for (int n = 0; n < 2; n++) begin
      for (int r = 0; r < 2; r++) begin
        doReset();
        requestPd(1'b0, 1'(n), 1'(r));
        chk("R2 locked entry", status[1:0], (n == 0) ? 1 : 0);
        chk("R8 regShutdown locked", regShutdown, (n == 0 && r == 1) ? 1 : 0);
        regOffEn = ~1'(r);
        @(negedge clk);
        chk("R8 regOffEn change ignored", regShutdown, (n == 0 && r == 1) ? 1 : 0);
      end
    end

    // R3: locked sleep ignores every wake source
    extIntEn = 8'hFF; extIntPol = 8'hFF;
    doReset();
    requestPd(1'b0, 1'b0, 1'b0);
    extIntPins = 8'hFF; rtcIrq = 1; canAct = 1; i2cAct = 1;
    repeat (10) @(negedge clk);
    chk("R3 locked holds", status[1:0], 1);
    chk("R3 no cause", status[7:4], 0);
    chk("R3 no wakeEvent", wakeEvent, 0);
    // R10: reset leaves locked sleep
    extRstN = 0;
    #1;
    chk("R10 reset from locked", status[1:0], 0);
    setIdle();
    @(negedge clk);
    extRstN = 1;
    @(negedge clk);

    // R4: entry qualification sweep on pins 3:0, pins 7:4 active but disabled
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        for (int l = 0; l < 16; l++) begin
          extIntPol = {4'hA, 4'(p)};
          extIntEn  = {4'h0, 4'(e)};
          doReset();
          extIntPins = {4'hA, 4'(l)};
          requestPd(1'b1, 1'b1, 1'b0);
          chk("R4 wakeable entry", status[1:0],
              ((~(4'(l) ^ 4'(p)) & 4'(e)) == 4'h0) ? 2 : 0);
        end
      end
    end

    // R6: pulse-width filter on every pin
    for (int pin = 0; pin < 8; pin++) begin
      for (int w = 1; w <= 6; w++) begin
        extIntPol = (pin % 2 == 0) ? 8'hFF : 8'h00;
        extIntEn  = 8'hFF;
        doReset();
        requestPd(1'b1, 1'b0, 1'b0);
        extIntPins[pin] = extIntPol[pin];
        repeat (w) @(negedge clk);
        extIntPins[pin] = ~extIntPol[pin];
        @(negedge clk);
        chk("R6 filter state", status[1:0], (w >= FILT) ? 3 : 2);
        chk("R6 filter cause", status[4], (w >= FILT) ? 1 : 0);
      end
    end
    // R6: disabled pin never wakes
    extIntPol = 8'hFF; extIntEn = 8'hFE;
    doReset();
    requestPd(1'b1, 1'b0, 1'b0);
    extIntPins[0] = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6 disabled pin", status[1:0], 2);
    extIntPins[0] = 1'b0;

    // R5, R7, R8: RTC wake, settling window
    extIntEn = 8'hFF;
    doReset();
    requestPd(1'b1, 1'b0, 1'b1);
    chk("R8 regShutdown wakeable", regShutdown, 1);
    rtcIrq = 1;
    @(negedge clk);
    rtcIrq = 0;
    chk("R5 rtc waking", status[1:0], 3);
    chk("R5 rtc cause", status[7:4], 4'b0010);
    chk("R5 wakeEvent", wakeEvent, 1);
    chk("R8 no shutdown waking", regShutdown, 0);
    wakingCycles = 0;
    while (status[1:0] == 2'd3 && wakingCycles < 50) begin
      if (!clkGate) chk("R7 gate in waking", clkGate, 1);
      if (wakingCycles == 1) chk("R5 wakeEvent single", wakeEvent, 0);
      wakingCycles++;
      @(negedge clk);
    end
    chk("R7 waking length", wakingCycles, STAB);
    chk("R7 back to run", status[1:0], 0);
    chk("R7 gate released", clkGate, 0);

    // R9: sticky cause, write-1-to-clear
    causeClr = 4'b0001;
    @(negedge clk);
    chk("R9 wrong bit keeps", status[7:4], 4'b0010);
    causeClr = 4'b0010;
    @(negedge clk);
    causeClr = 0;
    chk("R9 clear", status[7:4], 0);
    chk("R9 reserved zero", status[3:2], 0);

    // R5: CAN and I2C together
    requestPd(1'b1, 1'b0, 1'b0);
    canAct = 1; i2cAct = 1;
    @(negedge clk);
    canAct = 0; i2cAct = 0;
    chk("R5 can+i2c cause", status[7:4], 4'b1100);
    // R9: set wins over clear on the same edge
    repeat (STAB) @(negedge clk);
    requestPd(1'b1, 1'b0, 1'b0);
    canAct = 1; causeClr = 4'b1111;
    @(negedge clk);
    canAct = 0; causeClr = 0;
    chk("R9 set wins", status[7:4], 4'b0100);
    // R10: reset from WAKING
    extRstN = 0;
    #1;
    chk("R10 reset from waking", status[1:0], 0);
    @(negedge clk);
    extRstN = 1;
    @(negedge clk);
    requestPd(1'b1, 1'b0, 1'b0);
    extRstN = 0;
    #1;
    chk("R10 reset from wakeable", status[1:0], 0);
    @(negedge clk);
    extRstN = 1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule